// File: doc/BRIEF.md
# Multiplexed-Bus Control Register Interface

This block is the register bank that a host processor uses to configure and watch a line transceiver. The host reaches it over an 8-bit bus that carries the address and the data on the same wires. A strap input picks the strobe convention. In one convention there is an address latch enable, an active-low read strobe and an active-low write strobe. In the other there is an address strobe, an active-low data strobe and a read/write level. All strobes are sampled on a system clock, so bus sequencing is synchronous to that clock.

The bank holds three writable registers. Two of them are control registers whose fields drive the equalizer select, the data-format, all-ones and test-pattern pins. The third is an interrupt enable/clear register. There are also two read-only registers. The first shows live status. The second is a transition register that records each status change or elastic-store event. Any unmasked transition bit pulls a latched, active-low interrupt output low. The interrupt stays low until software masks or clears the source.

Top module: `mpx_ctrl_regs`

## Requirements
- R1: The address is captured from the bus while the address strobe is high. Only address bits 6..1 select a register and bits 7 and 0 are ignored. The selects (bits 6..1) are: first control 010000, second control 010001, interrupt enable/clear 010011, transition 010100, live status 010101.
- R2: With bus_mode=0, a read is active while cs_n=0 and strb_n=0. A write is taken once per low period of dir (write strobe, active low) while cs_n=0, using the data present on ad_in in the first clock where the write is seen.
- R3: With bus_mode=1, strb_n low with dir=1 reads, and strb_n low with dir=0 writes. Writes are taken once per strobe, as in R2.
- R4: In the first control register, bits 2..0 drive line_eq_sel and bit 4 drives unipolar_en. Bit 3 is reserved: it reads 0 whatever is written. Bits 7..5 also read 0.
- R5: In the second control register, bit 4 drives tx_all_ones and bits 6..5 drive pattern_sel. Bits 3..0 read 0.
- R6: The live status register reads drv_fail_open at bit 5 and selftest_ok at bit 6. All its other bits read 0.
- R7: A transition bit is set in the clock edge after its source changes. The bit positions are: bit 4 for any change of selftest_ok, bit 5 for any change of drv_fail_open, bit 6 for a rising es_ovf and bit 7 for a rising es_unf. A set bit holds, and irq_n stays low while any transition bit is set.
- R8: The interrupt enable/clear register bits 7..4 match the transition bits. Writing 1 clears that transition bit and keeps it from setting. Writing 0 enables the source again. The register reads back what was written in bits 7..4, and bits 3..0 read 0.
- R9: Writes to the live status, transition or unmapped addresses change no register. Reads of unmapped addresses return 0. ad_oe is high only during an active read, and ad_out is 0 whenever ad_oe is low.
- R10: Writing 1 to bit 7 of the second control register clears every register, every output field and the transition bits in that same write edge. Bit 7 itself always reads 0.
- R11: es_ovf and es_unf set their transition bits only on a rising edge. A held level or a falling edge sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | Strobe convention strap: 0 separate read/write strobes, 1 data strobe plus read/write level |
| cs_n | input | 1 | Chip select, active low |
| ale_as | input | 1 | Address latch enable / address strobe, active high |
| strb_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| dir | input | 1 | Write strobe active low (mode 0) or read/write level, 1 = read (mode 1) |
| ad_in | input | 8 | Multiplexed address/data from the host |
| ad_out | output | 8 | Read data toward the host |
| ad_oe | output | 1 | Drive enable for ad_out |
| drv_fail_open | input | 1 | Driver open-fault status |
| selftest_ok | input | 1 | Self-test pass status |
| es_ovf | input | 1 | Elastic store overflow event |
| es_unf | input | 1 | Elastic store underflow event |
| line_eq_sel | output | 3 | Line mode and equalizer select |
| unipolar_en | output | 1 | Unipolar data format enable |
| tx_all_ones | output | 1 | Transmit all-ones enable |
| pattern_sel | output | 2 | Internal test pattern select |
| irq_n | output | 1 | Latched interrupt, active low |

## Verification
Read data and ad_oe follow the strobes combinationally, and the live status reads straight through. The bench therefore samples them 5 ns after it asserts a read strobe on a falling clock edge. Writes, the self-clearing reset bit and transition capture each take effect on the first rising edge after the stimulus. The control pins and irq_n are checked on the following falling edge or later, never in the same half cycle as the stimulus. Event pulses last one full clock, so that exactly one rising edge sees each edge of a pulse.

// File: rtl/mpx_ctrl_regs.sv
`timescale 1ns/1ps
module mpx_ctrl_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_mode,
  input  logic       cs_n,
  input  logic       ale_as,
  input  logic       strb_n,
  input  logic       dir,
  input  logic [7:0] ad_in,
  output logic [7:0] ad_out,
  output logic       ad_oe,
  input  logic       drv_fail_open,
  input  logic       selftest_ok,
  input  logic       es_ovf,
  input  logic       es_unf,
  output logic [2:0] line_eq_sel,
  output logic       unipolar_en,
  output logic       tx_all_ones,
  output logic [1:0] pattern_sel,
  output logic       irq_n
);

  localparam int NSRC = 4;
  localparam logic [5:0] SEL_CTL1 = 6'b010000;
  localparam logic [5:0] SEL_CTL2 = 6'b010001;
  localparam logic [5:0] SEL_ICR  = 6'b010011;
  localparam logic [5:0] SEL_TSR  = 6'b010100;
  localparam logic [5:0] SEL_PSR  = 6'b010101;

  logic [5:0]      sel_q;
  logic            wr_q;
  logic [3:0]      ctl1_q;
  logic [2:0]      ctl2_q;
  logic [NSRC-1:0] mask_q, trans_q, mask_nxt, ev, src_now, src_q;
  logic [7:0]      rdata;

  logic rd_act, wr_act, wr_pulse;
  logic wr_ctl1, wr_ctl2, wr_icr, soft_rst;

  assign rd_act   = !cs_n && !strb_n && (bus_mode ? dir : 1'b1);
  assign wr_act   = !cs_n && (bus_mode ? (!strb_n && !dir) : !dir);
  assign wr_pulse = wr_act && !wr_q;

  assign wr_ctl1  = wr_pulse && (sel_q == SEL_CTL1);
  assign wr_ctl2  = wr_pulse && (sel_q == SEL_CTL2);
  assign wr_icr   = wr_pulse && (sel_q == SEL_ICR);
  assign soft_rst = wr_ctl2 && ad_in[7];

  assign src_now  = {es_unf, es_ovf, drv_fail_open, selftest_ok};
  assign ev       = {src_now[3] & ~src_q[3], src_now[2] & ~src_q[2],
                     src_now[1] ^ src_q[1],  src_now[0] ^ src_q[0]};
  assign mask_nxt = wr_icr ? ad_in[7:4] : mask_q;

  always_ff @(posedge clk)
    src_q <= src_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      wr_q    <= 1'b0;
      ctl1_q  <= '0;
      ctl2_q  <= '0;
      mask_q  <= '0;
      trans_q <= '0;
    end else begin
      if (ale_as) sel_q <= ad_in[6:1];
      wr_q <= wr_act;
      if (soft_rst) begin
        ctl1_q  <= '0;
        ctl2_q  <= '0;
        mask_q  <= '0;
        trans_q <= '0;
      end else begin
        if (wr_ctl1) ctl1_q <= {ad_in[4], ad_in[2:0]};
        if (wr_ctl2) ctl2_q <= ad_in[6:4];
        mask_q  <= mask_nxt;
        trans_q <= (trans_q | ev) & ~mask_nxt;
      end
    end
  end

  always_comb begin
    case (sel_q)
      SEL_CTL1: rdata = {3'b000, ctl1_q[3], 1'b0, ctl1_q[2:0]};
      SEL_CTL2: rdata = {1'b0, ctl2_q, 4'b0000};
      SEL_ICR:  rdata = {mask_q, 4'b0000};
      SEL_TSR:  rdata = {trans_q, 4'b0000};
      SEL_PSR:  rdata = {1'b0, selftest_ok, drv_fail_open, 5'b00000};
      default:  rdata = 8'h00;
    endcase
  end

  assign ad_oe       = rd_act;
  assign ad_out      = rd_act ? rdata : 8'h00;
  assign line_eq_sel = ctl1_q[2:0];
  assign unipolar_en = ctl1_q[3];
  assign tx_all_ones = ctl2_q[0];
  assign pattern_sel = ctl2_q[2:1];
  assign irq_n       = ~|trans_q;

  // R4: a write to the first control register shows on the pins next cycle
  p_ctl1_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl1 |=> (line_eq_sel == $past(ad_in[2:0])) && (unipolar_en == $past(ad_in[4])));

  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && sel_q == SEL_CTL1) |-> !ad_out[3]);

  p_latched_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !wr_pulse) |=> !irq_n);

  p_event_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(ev & ~mask_q)) && !wr_pulse) |=> !irq_n);

  p_mask_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_icr && ad_in[5]) |=> !trans_q[1]);

  p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && sel_q != SEL_CTL1 && sel_q != SEL_CTL2 && sel_q != SEL_ICR)
      |=> ($stable(ctl1_q) && $stable(ctl2_q) && $stable(mask_q)));

  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctl1_q == '0 && ctl2_q == '0 && mask_q == '0 && irq_n));

endmodule

// File: tb/mpx_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module mpx_ctrl_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_mode = 1'b0, cs_n = 1'b1, ale_as = 1'b0, strb_n = 1'b1, dir = 1'b1;
  logic [7:0] ad_in = 8'h00;
  logic [7:0] ad_out;
  logic ad_oe;
  logic drv_fail_open = 1'b0, selftest_ok = 1'b0, es_ovf = 1'b0, es_unf = 1'b0;
  logic [2:0] line_eq_sel;
  logic unipolar_en, tx_all_ones, irq_n;
  logic [1:0] pattern_sel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mpx_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n), .ale_as(ale_as),
    .strb_n(strb_n), .dir(dir), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .drv_fail_open(drv_fail_open), .selftest_ok(selftest_ok), .es_ovf(es_ovf),
    .es_unf(es_unf), .line_eq_sel(line_eq_sel), .unipolar_en(unipolar_en),
    .tx_all_ones(tx_all_ones), .pattern_sel(pattern_sel), .irq_n(irq_n));

  // {mode, write addr, write data, read addr, expected, requirement number}
  localparam int NV = 8;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 8'h20, 8'hFF, 8'h20, 8'h17, 4'd4},  // R4 R2: reserved bit 3 dropped
    {1'b1, 8'hA1, 8'h05, 8'h20, 8'h05, 4'd1},  // R1 R3: bits 7 and 0 ignored
    {1'b0, 8'h22, 8'h7F, 8'h23, 8'h70, 4'd5},  // R5
    {1'b1, 8'h22, 8'h20, 8'hA2, 8'h20, 4'd5},  // R5 R3
    {1'b0, 8'h26, 8'hF0, 8'h26, 8'hF0, 4'd8},  // R8 readback
    {1'b0, 8'h26, 8'h0F, 8'h26, 8'h00, 4'd8},  // R8 low bits read 0
    {1'b1, 8'h24, 8'hFF, 8'h24, 8'h00, 4'd9},  // R9 unmapped
    {1'b0, 8'h2A, 8'hFF, 8'h20, 8'h05, 4'd9}   // R9 read-only write ignored
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic m, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_mode = m; cs_n = 1'b0; ale_as = 1'b1; ad_in = a;
    @(negedge clk); ale_as = 1'b0;
    @(negedge clk); ad_in = d; dir = 1'b0; if (m) strb_n = 1'b0;
    @(negedge clk); strb_n = 1'b1; dir = 1'b1; cs_n = 1'b1;
  endtask

  task automatic bus_read(input logic m, input logic [7:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); bus_mode = m; cs_n = 1'b0; ale_as = 1'b1; ad_in = a;
    @(negedge clk); ale_as = 1'b0; ad_in = 8'h00;
    @(negedge clk); dir = 1'b1; strb_n = 1'b0;
    #5; d = ad_out; oe = ad_oe;
    @(negedge clk); strb_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic oe;
    bus_read(1'b0, a, d, oe);
    check(req, {7'b0, oe}, 8'h01);
    check(req, d, exp);
  endtask

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state of pins
    check("R10 reset irq_n", {7'b0, irq_n}, 8'h01);
    check("R9 reset ad_oe", {7'b0, ad_oe}, 8'h00);
    check("R4 reset eq", {5'b0, line_eq_sel}, 8'h00);
    rd_chk("R4 reset ctl1", 8'h20, 8'h00);

    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][36], VEC[i][35:28], VEC[i][27:20]);
      bus_read(VEC[i][36], VEC[i][19:12], d, oe);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), d, VEC[i][11:4]);
      check($sformatf("R%0d vector %0d oe", VEC[i][3:0], i), {7'b0, oe}, 8'h01);
    end
    check("R4 eq pins", {5'b0, line_eq_sel}, 8'h05);
    check("R4 unipolar pin", {7'b0, unipolar_en}, 8'h00);
    check("R5 pattern pins", {5'b0, pattern_sel, tx_all_ones}, 8'h02);

    // R9: select off with strobe low, no drive
    @(negedge clk); strb_n = 1'b0; cs_n = 1'b1;
    #5; check("R9 no drive without cs", {ad_oe, ad_out[6:0]}, 8'h00);
    @(negedge clk); strb_n = 1'b1;

    // R6 R7: status change latched
    @(negedge clk); drv_fail_open = 1'b1; selftest_ok = 1'b1;
    @(negedge clk);
    check("R7 irq low after change", {7'b0, irq_n}, 8'h00);
    rd_chk("R6 live status", 8'h2A, 8'h60);
    @(negedge clk); selftest_ok = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 irq held", {7'b0, irq_n}, 8'h00);
    rd_chk("R7 transition bits", 8'h28, 8'h30);

    // R8: clear and mask, then re-enable
    bus_write(1'b0, 8'h26, 8'h30);
    check("R8 clear releases irq", {7'b0, irq_n}, 8'h01);
    @(negedge clk); drv_fail_open = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 masked source quiet", {7'b0, irq_n}, 8'h01);
    rd_chk("R8 masked transition", 8'h28, 8'h00);
    bus_write(1'b1, 8'h26, 8'h00);
    @(negedge clk); drv_fail_open = 1'b1;
    @(negedge clk);
    check("R8 enabled source irq", {7'b0, irq_n}, 8'h00);
    rd_chk("R8 enabled transition", 8'h28, 8'h20);

    // R11: edge-only elastic store events
    bus_write(1'b0, 8'h26, 8'hF0);
    bus_write(1'b0, 8'h26, 8'h00);
    @(negedge clk); es_ovf = 1'b1;
    @(negedge clk); es_ovf = 1'b0;
    repeat (2) @(negedge clk);
    rd_chk("R11 overflow rise", 8'h28, 8'h40);
    bus_write(1'b0, 8'h26, 8'hF0);
    bus_write(1'b0, 8'h26, 8'h00);
    @(negedge clk); es_unf = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk("R11 underflow rise", 8'h28, 8'h80);
    bus_write(1'b0, 8'h26, 8'hF0);
    bus_write(1'b0, 8'h26, 8'h00);
    repeat (3) @(negedge clk);
    rd_chk("R11 held level no set", 8'h28, 8'h00);
    check("R11 irq idle", {7'b0, irq_n}, 8'h01);

    // R10: self-clearing reset bit
    bus_write(1'b0, 8'h20, 8'h13);
    bus_write(1'b1, 8'h22, 8'h70);
    bus_write(1'b0, 8'h26, 8'h80);
    @(negedge clk); drv_fail_open = 1'b0;
    @(negedge clk);
    check("R10 pre irq", {7'b0, irq_n}, 8'h00);
    bus_write(1'b0, 8'h22, 8'h80);
    check("R10 irq cleared", {7'b0, irq_n}, 8'h01);
    check("R10 pins cleared", {unipolar_en, tx_all_ones, pattern_sel, 1'b0, line_eq_sel}, 8'h00);
    rd_chk("R10 ctl1 zero", 8'h20, 8'h00);
    rd_chk("R10 ctl2 zero", 8'h22, 8'h00);
    rd_chk("R10 icr zero", 8'h26, 8'h00);
    rd_chk("R10 transition zero", 8'h28, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule